// File: doc/BRIEF.md
# Fault-Injectable One-Hot Line Decoder

This block turns a two-bit address into one active line out of four. On request it corrupts that decode so that test logic and fault simulators further along can see the three functional decoder faults: the wrong line picked, an extra line picked as well, or no line picked at all. A fault affects only one address, the victim. Every other address decodes normally.

The fault setup is held in a small state machine whose state is the active fault mode. It sits beside a victim index and an alias index. All three are loaded together on a synchronous load strobe. The decode path is purely combinational from the address and the held setup. A mismatch flag compares the line vector with a clean decode of the same address, so any corruption that reaches the outputs shows on that flag.

The mode machine has four states: MODE_CLEAN, MODE_SWAP, MODE_EXTRA and MODE_DROP. Reset puts it in MODE_CLEAN. On a clock edge where the load strobe is high, it moves from any state to the state selected by the kind code: 00 goes to MODE_CLEAN, 01 to MODE_SWAP, 10 to MODE_EXTRA and 11 to MODE_DROP. If the enable input is low on that edge, it goes to MODE_CLEAN whatever the kind code is. On any edge without the strobe, it stays in its current state.

Top module: `fidec_top`

## Requirements
- R1: While rst_n is low, and after reset until the first load, the block is fault-free: lines equals 1 shifted left by addr, and mismatch is 0.
- R2: In the fault-free mode, lines has exactly one bit set, at bit position addr, for all four addresses.
- R3: fault_en, fault_kind, victim and alias_idx are captured only on a rising clk edge where cfg_load is 1. Changing them without cfg_load has no effect on lines.
- R4: With kind 01 (substitution) loaded and addr equal to victim, lines has only the bit at position alias_idx set.
- R5: With kind 10 (additive) loaded and addr equal to victim, lines has bits victim and alias_idx set. When alias_idx equals victim, lines is the normal one-hot value.
- R6: With kind 11 (null) loaded and addr equal to victim, lines is all zero.
- R7: Under any loaded mode, an addr different from victim gives the normal one-hot value with mismatch 0.
- R8: A load with fault_en 0, or with kind 00, returns the block to fault-free decoding for every address.
- R9: mismatch is 1 exactly when lines differs from 1 shifted left by addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault setup registers |
| rst_n | input | 1 | Active-low synchronous reset to fault-free |
| cfg_load | input | 1 | Strobe that captures the fault setup |
| fault_en | input | 1 | Enable for the fault being loaded |
| fault_kind | input | 2 | Fault kind: 00 none, 01 substitution, 10 additive, 11 null |
| victim | input | 2 | Address whose decode is corrupted |
| alias_idx | input | 2 | Second line used by substitution and additive faults |
| addr | input | 2 | Address to decode |
| lines | output | 4 | Decoded line vector |
| mismatch | output | 1 | High when lines differs from a clean decode |

## Verification
A wrong mode state or victim register shows up at the ports in the same cycle the address reaches the victim. The output path has no register, so the line vector and the mismatch flag change at once. A setup captured at the wrong edge, or without the strobe, shows up on the first address sweep after that edge. The bench therefore sweeps all four addresses after every load, and also after input changes that should not be captured. A fault that leaks onto other addresses is caught by the sweep over the addresses that are not the victim.

// File: rtl/fidec_pkg.sv
package fidec_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAN = 2'b00,
        MODE_SWAP  = 2'b01,
        MODE_EXTRA = 2'b10,
        MODE_DROP  = 2'b11
    } fault_mode_e;

endpackage

// File: rtl/fidec_cfg.sv
module fidec_cfg
    import fidec_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             fault_en,
    input  logic [1:0]       fault_kind,
    input  logic [SEL_W-1:0] victim,
    input  logic [SEL_W-1:0] alias_idx,
    output fault_mode_e      mode_q,
    output logic [SEL_W-1:0] victim_q,
    output logic [SEL_W-1:0] alias_q
);

    fault_mode_e mode_d;

    // State register for the fault mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CLEAN;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Next-state logic: only a load strobe changes the mode.
    always_comb begin
        mode_d = mode_q;
        if (cfg_load) begin
            if (!fault_en) begin
                mode_d = MODE_CLEAN;
            end else begin
                unique case (fault_kind)
                    2'b00: mode_d = MODE_CLEAN;
                    2'b01: mode_d = MODE_SWAP;
                    2'b10: mode_d = MODE_EXTRA;
                    2'b11: mode_d = MODE_DROP;
                    default: mode_d = MODE_CLEAN;
                endcase
            end
        end
    end

    // Line indices travel with the mode on the same strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= '0;
            alias_q  <= '0;
        end else if (cfg_load) begin
            victim_q <= victim;
            alias_q  <= alias_idx;
        end
    end

endmodule

// File: rtl/fidec_golden.sv
module fidec_golden #(
    parameter int SEL_W = 2,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] hot
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hot[i] = (sel == SEL_W'(i));
    end

endmodule

// File: rtl/fidec_inject.sv
module fidec_inject
    import fidec_pkg::*;
#(
    parameter int SEL_W = 2,
    localparam int LINES = 1 << SEL_W
) (
    input  fault_mode_e      mode_q,
    input  logic [SEL_W-1:0] addr,
    input  logic [SEL_W-1:0] victim_q,
    input  logic [LINES-1:0] clean_hot,
    input  logic [LINES-1:0] alias_hot,
    output logic [LINES-1:0] lines
);

    logic hit;
    assign hit = (addr == victim_q);

    // Output process: the corruption is chosen by the mode state.
    always_comb begin
        lines = clean_hot;
        unique case (mode_q)
            MODE_CLEAN: lines = clean_hot;
            MODE_SWAP:  lines = hit ? alias_hot : clean_hot;
            MODE_EXTRA: lines = hit ? (clean_hot | alias_hot) : clean_hot;
            MODE_DROP:  lines = hit ? '0 : clean_hot;
            default:    lines = clean_hot;
        endcase
    end

endmodule

// File: rtl/fidec_top.sv
module fidec_top
    import fidec_pkg::*;
#(
    parameter int SEL_W = 2,
    localparam int LINES = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             fault_en,
    input  logic [1:0]       fault_kind,
    input  logic [SEL_W-1:0] victim,
    input  logic [SEL_W-1:0] alias_idx,
    input  logic [SEL_W-1:0] addr,
    output logic [LINES-1:0] lines,
    output logic             mismatch
);

    fault_mode_e      mode_q;
    logic [SEL_W-1:0] victim_q;
    logic [SEL_W-1:0] alias_q;
    logic [LINES-1:0] clean_hot;
    logic [LINES-1:0] alias_hot;

    fidec_cfg #(.SEL_W(SEL_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .fault_en   (fault_en),
        .fault_kind (fault_kind),
        .victim     (victim),
        .alias_idx  (alias_idx),
        .mode_q     (mode_q),
        .victim_q   (victim_q),
        .alias_q    (alias_q)
    );

    fidec_golden #(.SEL_W(SEL_W)) u_clean (
        .sel (addr),
        .hot (clean_hot)
    );

    fidec_golden #(.SEL_W(SEL_W)) u_alias (
        .sel (alias_q),
        .hot (alias_hot)
    );

    fidec_inject #(.SEL_W(SEL_W)) u_inject (
        .mode_q    (mode_q),
        .addr      (addr),
        .victim_q  (victim_q),
        .clean_hot (clean_hot),
        .alias_hot (alias_hot),
        .lines     (lines)
    );

    assign mismatch = (lines != clean_hot);

endmodule

// File: rtl/fidec_chk.sv
module fidec_chk
    import fidec_pkg::*;
#(
    parameter int SEL_W = 2,
    localparam int LINES = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [SEL_W-1:0] addr,
    input logic [LINES-1:0] lines,
    input logic             mismatch,
    input fault_mode_e      mode_q,
    input logic [SEL_W-1:0] victim_q
);

    assert_clean_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CLEAN) |-> ($countones(lines) == 1 && lines[addr]));

    assert_hold_without_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(mode_q));

    assert_swap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SWAP) |-> ($countones(lines) == 1));

    assert_drop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DROP && addr == victim_q) |-> (lines == '0 && mismatch));

    assert_off_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != victim_q) |-> (!mismatch && $countones(lines) == 1 && lines[addr]));

    assert_clean_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CLEAN) |-> !mismatch);

endmodule

bind fidec_top fidec_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .addr     (addr),
    .lines    (lines),
    .mismatch (mismatch),
    .mode_q   (mode_q),
    .victim_q (victim_q)
);

// File: tb/tb_fidec_top.sv
module tb_fidec_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       fault_en = 1'b0;
    logic [1:0] fault_kind = 2'b00;
    logic [1:0] victim = 2'b00;
    logic [1:0] alias_idx = 2'b00;
    logic [1:0] addr = 2'b00;
    logic [3:0] lines;
    logic       mismatch;

    int n_run = 0;
    int n_fail = 0;

    // Bench copy of the loaded setup, tracked from the requirements.
    logic       m_en = 1'b0;
    logic [1:0] m_kind = 2'b00;
    logic [1:0] m_vic = 2'b00;
    logic [1:0] m_ali = 2'b00;

    fidec_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .fault_en   (fault_en),
        .fault_kind (fault_kind),
        .victim     (victim),
        .alias_idx  (alias_idx),
        .addr       (addr),
        .lines      (lines),
        .mismatch   (mismatch)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] expect_lines(input logic [1:0] a);
        logic [3:0] one = 4'b0001 << a;
        if (!m_en || m_kind == 2'b00 || a != m_vic) return one;
        case (m_kind)
            2'b01:   return 4'b0001 << m_ali;
            2'b10:   return one | (4'b0001 << m_ali);
            default: return 4'b0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] a);
        logic [3:0] el = expect_lines(a);
        logic       em = (el != (4'b0001 << a));
        n_run++;
        if (lines !== el || mismatch !== em) begin
            n_fail++;
            $display("FAIL %s addr=%0d lines=%b/%b mismatch=%b expected lines=%b mismatch=%b",
                     req, a, lines, mismatch, el, em, );
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            addr = 2'(i);
            #1;
            check(req, 2'(i));
        end
    endtask

    task automatic load(input logic en, input logic [1:0] k,
                        input logic [1:0] v, input logic [1:0] a);
        @(negedge clk);
        cfg_load = 1'b1; fault_en = en; fault_kind = k; victim = v; alias_idx = a;
        @(posedge clk);
        m_en = en; m_kind = k; m_vic = v; m_ali = a;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            addr = 2'(i);
            #1;
            check("R1", 2'(i));
        end
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");
    endtask

    task automatic t_clean();
        load(1'b1, 2'b00, 2'd2, 2'd1);
        sweep("R2");
    endtask

    task automatic t_no_load();
        load(1'b1, 2'b11, 2'd1, 2'd0);
        @(negedge clk);
        fault_kind = 2'b01; victim = 2'd3; alias_idx = 2'd2;
        repeat (3) @(negedge clk);
        sweep("R3");
    endtask

    task automatic t_subst();
        load(1'b1, 2'b01, 2'd0, 2'd3);
        sweep("R4");
        load(1'b1, 2'b01, 2'd2, 2'd1);
        sweep("R4");
        sweep("R9");
    endtask

    task automatic t_additive();
        load(1'b1, 2'b10, 2'd1, 2'd2);
        sweep("R5");
        load(1'b1, 2'b10, 2'd3, 2'd3);
        sweep("R5");
    endtask

    task automatic t_null();
        load(1'b1, 2'b11, 2'd3, 2'd0);
        sweep("R6");
        sweep("R7");
    endtask

    task automatic t_disable();
        load(1'b1, 2'b11, 2'd0, 2'd0);
        load(1'b0, 2'b11, 2'd0, 2'd2);
        sweep("R8");
        load(1'b1, 2'b01, 2'd1, 2'd0);
        load(1'b1, 2'b00, 2'd1, 2'd0);
        sweep("R8");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_clean();
                t_no_load();
                t_subst();
                t_additive();
                t_null();
                t_disable();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule